// File: doc/BRIEF.md
# Edge Timestamp Capture Unit

This block records when a selected transition happens on an external capture pin, measured against a free-running counter that lives outside the block. The pin first passes through a two-flop synchronizer. An optional debounce stage can follow it, which accepts a new pin level only once that level has been seen on four consecutive synchronized samples. When the chosen transition (rising or falling) reaches the edge detector, the counter value present at that clock edge is latched into a capture register. A sticky capture flag is set at the same time, and it can raise an interrupt request.

Software sets a small control word, clears the flag with a strobe, and raises a disable input whenever the capture register is being used as the counter's wrap value. While that disable is high, captures and flag setting are suppressed. The edge detector keeps following the pin the whole time, so no stale edge is replayed once the disable is lifted.

Top module: `tstamp_capture`

## Requirements
- R1: With the debounce off (`ctrl_i[0]`=0), a pin change driven just before clock edge k is captured at edge k+2, so the flag reads high after edge k+2 (two synchronizer flops plus one detector stage).
- R2: With the debounce on (`ctrl_i[0]`=1), the same capture happens exactly four clock edges later, at edge k+6.
- R3: With the debounce on, the filtered level changes only after four consecutive synchronized samples all show the new value. A pulse lasting three clocks produces no capture, and a pulse lasting four clocks does.
- R4: `ctrl_i[1]`=0 selects a falling edge as the trigger and `ctrl_i[1]`=1 selects a rising edge. The opposite edge causes no capture.
- R5: On a capture, `cap_val_o` takes the `count_i` value present at the capturing clock edge. It holds that value until the next capture.
- R6: `cap_flag_o` is set by a capture and stays set until `flag_clr_i` is high at a clock edge. If a capture and a clear occur at the same edge, the flag stays set.
- R7: `cap_irq_o` is high exactly when `cap_flag_o` is high and the interrupt enable `ctrl_i[3]` is 1.
- R8: While `cap_dis_i` is high, no capture occurs: `cap_val_o` does not change and the flag is not set.
- R9: `ctrl_i[2]` is reserved. Its value has no effect on any output.
- R10: A synchronous active-high `rst` clears `cap_val_o`, `cap_flag_o`, `cap_irq_o` and all pin history to zero.
- R11: Changing `ctrl_i[1]` while the pin is steady produces no capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cap_pin_i | input | 1 | Asynchronous capture pin |
| count_i | input | 16 | Free-running counter value |
| ctrl_i | input | 4 | [0] debounce enable, [1] rising-edge select, [2] reserved, [3] interrupt enable |
| flag_clr_i | input | 1 | Strobe that clears the capture flag |
| cap_dis_i | input | 1 | Suppresses capture (capture register in use as wrap value) |
| cap_val_o | output | 16 | Captured counter value |
| cap_flag_o | output | 1 | Sticky capture flag |
| cap_irq_o | output | 1 | Interrupt request |

## Verification
Single isolated transitions under each combination of edge select and debounce give the absolute capture latency, which separates a missing or extra pipeline stage from a correct one (3 versus 7 clocks). Pulses of three and four clocks with the debounce on test the boundary of the run-length rule. Steady pin levels combined with toggled edge select, the disable input or the reserved bit show that no spurious capture appears. A long random stretch mixes pin bursts, clears and disables, and compares every cycle against a queue-based reference model.

// File: rtl/tsc_pkg.sv
package tsc_pkg;

    localparam int unsigned TSC_CNT_W     = 16;
    localparam int unsigned TSC_SYNC_LEN  = 2;
    localparam int unsigned TSC_DEB_LEN   = 4;
    localparam int unsigned TSC_CTRL_W    = 4;

    // Decoded control word; the reserved position is deliberately absent.
    typedef struct packed {
        logic irq_en;
        logic rise_sel;
        logic deb_en;
    } tsc_ctrl_t;

    // Edge detector result carried between stages.
    typedef struct packed {
        logic level;
        logic hit;
    } tsc_edge_t;

    function automatic tsc_ctrl_t tsc_decode(input logic [TSC_CTRL_W-1:0] raw);
        tsc_ctrl_t c;
        c.deb_en   = raw[0];
        c.rise_sel = raw[1];
        c.irq_en   = raw[3];
        return c;
    endfunction

    function automatic logic tsc_all_equal(input logic [TSC_DEB_LEN-1:0] v);
        return (&v) | ~(|v);
    endfunction

endpackage

// File: rtl/tsc_sync.sv
module tsc_sync #(
    parameter int unsigned STAGES = tsc_pkg::TSC_SYNC_LEN
) (
    input  logic clk,
    input  logic rst,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain_q;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) chain_q <= '0;
                else     chain_q <= d_i;
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (rst) chain_q <= '0;
                else     chain_q <= {chain_q[STAGES-2:0], d_i};
            end
        end
    endgenerate

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/tsc_debounce.sv
module tsc_debounce #(
    parameter int unsigned RUN = tsc_pkg::TSC_DEB_LEN
) (
    input  logic clk,
    input  logic rst,
    input  logic d_i,
    output logic q_o
);
    localparam int unsigned HW = (RUN > 1) ? RUN - 1 : 1;

    logic [HW-1:0] hist_q;
    logic          filt_q;
    logic          run_ok;

    generate
        if (RUN <= 1) begin : g_bypass
            assign run_ok = 1'b1;
            always_ff @(posedge clk) begin
                if (rst) hist_q <= '0;
                else     hist_q <= d_i;
            end
        end else begin : g_run
            logic [RUN-1:0] win;
            assign win    = {hist_q, d_i};
            assign run_ok = (&win) | ~(|win);
            if (HW == 1) begin : g_h1
                always_ff @(posedge clk) begin
                    if (rst) hist_q <= '0;
                    else     hist_q <= d_i;
                end
            end else begin : g_hn
                always_ff @(posedge clk) begin
                    if (rst) hist_q <= '0;
                    else     hist_q <= {hist_q[HW-2:0], d_i};
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst)         filt_q <= 1'b0;
        else if (run_ok) filt_q <= d_i;
    end

    assign q_o = filt_q;

    // R3: the filtered level never moves unless the sample run was uniform
    a_r3_run_before_change: assert property (@(posedge clk) disable iff (rst)
        !$stable(filt_q) |-> $past(run_ok));
endmodule

// File: rtl/tsc_edge.sv
module tsc_edge
    import tsc_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      raw_i,
    input  logic      deb_i,
    input  tsc_ctrl_t ctrl_i,
    input  logic      dis_i,
    output tsc_edge_t ev_o
);
    logic level;
    logic prev_q;

    assign level = ctrl_i.deb_en ? deb_i : raw_i;

    // History follows the pin regardless of edge select or disable.
    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= level;
    end

    assign ev_o.level = level;
    assign ev_o.hit   = (level != prev_q) && (level == ctrl_i.rise_sel) && !dis_i;

    // R4: a hit always marks a level that matches the selected polarity
    a_r4_polarity: assert property (@(posedge clk) disable iff (rst)
        ev_o.hit |=> (prev_q == $past(ctrl_i.rise_sel)));
endmodule

// File: rtl/tsc_capture.sv
module tsc_capture
    import tsc_pkg::*;
#(
    parameter int unsigned CNT_W = TSC_CNT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             hit_i,
    input  logic [CNT_W-1:0] count_i,
    input  logic             clr_i,
    input  logic             irq_en_i,
    output logic [CNT_W-1:0] val_o,
    output logic             flag_o,
    output logic             irq_o
);
    logic [CNT_W-1:0] val_q;
    logic             flag_q;

    always_ff @(posedge clk) begin
        if (rst)        val_q <= '0;
        else if (hit_i) val_q <= count_i;
    end

    always_ff @(posedge clk) begin
        if (rst)        flag_q <= 1'b0;
        else if (hit_i) flag_q <= 1'b1;
        else if (clr_i) flag_q <= 1'b0;
    end

    assign val_o  = val_q;
    assign flag_o = flag_q;
    assign irq_o  = flag_q & irq_en_i;

    a_r5_load: assert property (@(posedge clk) disable iff (rst)
        hit_i |=> (val_q == $past(count_i)));
    a_r5_hold: assert property (@(posedge clk) disable iff (rst)
        !hit_i |=> $stable(val_q));
    a_r6_capture_wins: assert property (@(posedge clk) disable iff (rst)
        (hit_i && clr_i) |=> flag_q);
    a_r6_sticky: assert property (@(posedge clk) disable iff (rst)
        (flag_q && !clr_i) |=> flag_q);
    a_r7_irq_needs_flag: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> flag_o);
endmodule

// File: rtl/tstamp_capture.sv
module tstamp_capture
    import tsc_pkg::*;
#(
    parameter int unsigned CNT_W    = TSC_CNT_W,
    parameter int unsigned SYNC_LEN = TSC_SYNC_LEN,
    parameter int unsigned DEB_LEN  = TSC_DEB_LEN
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  cap_pin_i,
    input  logic [CNT_W-1:0]      count_i,
    input  logic [TSC_CTRL_W-1:0] ctrl_i,
    input  logic                  flag_clr_i,
    input  logic                  cap_dis_i,
    output logic [CNT_W-1:0]      cap_val_o,
    output logic                  cap_flag_o,
    output logic                  cap_irq_o
);
    tsc_ctrl_t ctrl;
    tsc_edge_t ev;
    logic      pin_s;
    logic      pin_f;

    assign ctrl = tsc_decode(ctrl_i);

    tsc_sync #(.STAGES(SYNC_LEN)) u_sync (
        .clk (clk),
        .rst (rst),
        .d_i (cap_pin_i),
        .q_o (pin_s)
    );

    tsc_debounce #(.RUN(DEB_LEN)) u_deb (
        .clk (clk),
        .rst (rst),
        .d_i (pin_s),
        .q_o (pin_f)
    );

    tsc_edge u_edge (
        .clk    (clk),
        .rst    (rst),
        .raw_i  (pin_s),
        .deb_i  (pin_f),
        .ctrl_i (ctrl),
        .dis_i  (cap_dis_i),
        .ev_o   (ev)
    );

    tsc_capture #(.CNT_W(CNT_W)) u_cap (
        .clk      (clk),
        .rst      (rst),
        .hit_i    (ev.hit),
        .count_i  (count_i),
        .clr_i    (flag_clr_i),
        .irq_en_i (ctrl.irq_en),
        .val_o    (cap_val_o),
        .flag_o   (cap_flag_o),
        .irq_o    (cap_irq_o)
    );

    // R8: with capture suppressed a clear flag cannot become set
    a_r8_dis_no_set: assert property (@(posedge clk) disable iff (rst)
        (cap_dis_i && !cap_flag_o) |=> !cap_flag_o);
    a_r8_dis_val_hold: assert property (@(posedge clk) disable iff (rst)
        cap_dis_i |=> $stable(cap_val_o));
endmodule

// File: tb/tb_tstamp_capture.sv
module tb_tstamp_capture;
    logic        clk = 1'b0;
    logic        rst;
    logic        pin;
    logic [15:0] cnt;
    logic [3:0]  ctrl;
    logic        clr;
    logic        dis;
    logic [15:0] val;
    logic        flag;
    logic        irq;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 0;

    always #2 clk = ~clk;

    tstamp_capture dut (
        .clk(clk), .rst(rst), .cap_pin_i(pin), .count_i(cnt), .ctrl_i(ctrl),
        .flag_clr_i(clr), .cap_dis_i(dis),
        .cap_val_o(val), .cap_flag_o(flag), .cap_irq_o(irq)
    );

    // free-running counter, changes away from the rising edge
    always @(negedge clk) begin
        if (rst) cnt <= 16'h1000;
        else     cnt <= cnt + 16'd7;
    end

    // ---------------- reference model ----------------
    bit          pq[$];       // pin samples, newest first
    bit          m_filt, m_prev, m_flag;
    logic [15:0] m_val;

    always @(posedge clk) begin
        bit lvl, hit;
        if (rst) begin
            pq = {0, 0, 0, 0, 0};
            m_filt = 0; m_prev = 0; m_flag = 0; m_val = '0;
        end else begin
            lvl = ctrl[0] ? m_filt : pq[1];
            hit = (lvl != m_prev) && (lvl == ctrl[1]) && !dis;
            if (hit) begin
                m_val = cnt; m_flag = 1;
            end else if (clr) m_flag = 0;
            m_prev = lvl;
            if (pq[1] == pq[2] && pq[2] == pq[3] && pq[3] == pq[4]) m_filt = pq[1];
            pq.push_front(pin);
            void'(pq.pop_back());
        end
    end

    // compare one time unit after every rising edge
    always @(posedge clk) begin
        #1;
        if (!rst && !done) begin
            n_cmp++;
            if (val !== m_val) begin
                n_bad++;
                $display("FAIL R5 cap_val: actual %h expected %h", val, m_val);
            end
            n_cmp++;
            if (flag !== m_flag) begin
                n_bad++;
                $display("FAIL R6 cap_flag: actual %b expected %b", flag, m_flag);
            end
            n_cmp++;
            if (irq !== (m_flag & ctrl[3])) begin
                n_bad++;
                $display("FAIL R7 cap_irq: actual %b expected %b", irq, m_flag & ctrl[3]);
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clear_flag();
        clr = 1; step(1); clr = 0;
    endtask

    // counts rising edges from a change made at a falling edge until the flag shows
    task automatic measure(output int n);
        n = 0;
        do begin
            @(posedge clk); #1; n++;
        end while (!flag && n < 20);
        @(negedge clk);
    endtask

    initial begin
        int lat;
        logic [15:0] held;
        rst = 1; pin = 0; ctrl = 4'b0000; clr = 0; dis = 0;
        step(3);
        rst = 0;
        step(1);
        chk(val == 0 && flag == 0 && irq == 0, "R10 reset state", {val, flag, irq}, 0);

        // R1 plain latency, falling trigger
        pin = 1; step(6); clear_flag();
        pin = 0; measure(lat);
        chk(lat == 3, "R1 unfiltered latency", lat, 3);
        clear_flag();

        // R2 debounced latency
        ctrl = 4'b0001; pin = 1; step(10); clear_flag();
        pin = 0; measure(lat);
        chk(lat == 7, "R2 filtered latency", lat, 7);
        clear_flag(); step(8);

        // R3 short and exact pulses, rising trigger
        ctrl = 4'b0011; step(2); clear_flag();
        pin = 1; step(3); pin = 0; step(15);
        chk(flag == 0, "R3 three-clock pulse rejected", flag, 0);
        pin = 1; step(4); pin = 0; step(15);
        chk(flag == 1, "R3 four-clock pulse accepted", flag, 1);
        clear_flag();

        // R4 polarity
        ctrl = 4'b0010; pin = 1; step(6); clear_flag();
        pin = 0; step(6);
        chk(flag == 0, "R4 falling ignored when rising selected", flag, 0);
        pin = 1; step(6);
        chk(flag == 1, "R4 rising captured", flag, 1);
        clear_flag();

        // R11 edge-select toggles on steady pin
        repeat (3) begin
            ctrl[1] = ~ctrl[1]; step(2);
        end
        pin = 0; step(6); clear_flag();
        repeat (4) begin
            ctrl[1] = ~ctrl[1]; step(3);
        end
        chk(flag == 0, "R11 select change alone", flag, 0);

        // R9 reserved bit has no effect on latency or result
        ctrl = 4'b0100; pin = 1; step(6); clear_flag();
        pin = 0; measure(lat);
        chk(lat == 3, "R9 reserved bit set", lat, 3);
        clear_flag();

        // R8 disable
        ctrl = 4'b0010; held = val; dis = 1;
        pin = 1; step(5); pin = 0; step(5); pin = 1; step(5);
        chk(flag == 0, "R8 no flag while disabled", flag, 0);
        chk(val == held, "R8 value held while disabled", val, held);
        dis = 0; step(6);
        chk(flag == 0, "R8 no replay after enable", flag, 0);

        // R6 capture and clear in the same cycle
        pin = 0; step(6);
        pin = 1; step(2); clr = 1; step(1); clr = 0;
        chk(flag == 1, "R6 capture wins over clear", flag, 1);
        step(3);
        chk(flag == 1, "R6 flag sticky", flag, 1);

        // R7 interrupt gating
        ctrl = 4'b1010; step(1);
        chk(irq == 1, "R7 irq enabled", irq, 1);
        ctrl = 4'b0010; step(1);
        chk(irq == 0, "R7 irq masked", irq, 0);
        clear_flag();
        chk(flag == 0, "R6 clear alone", flag, 0);

        // R5 random traffic checked by the model every cycle
        for (int i = 0; i < 3000; i++) begin
            if ($urandom_range(0, 5) == 0) pin = ~pin;
            if ($urandom_range(0, 40) == 0) ctrl = 4'($urandom);
            clr = ($urandom_range(0, 9) == 0);
            dis = ($urandom_range(0, 15) == 0);
            step(1);
        end
        clr = 0; dis = 0;
        step(4);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule